// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short global record of how the most recently resolved branches went. That record chooses one of several banks of saturating counters. The low bits of the branch address then pick one counter inside the chosen bank, and the top bit of that counter is the guess. Because the record picks the bank, the same branch address can be given different guesses depending on what the branches before it did.

The fetch side puts an address on the prediction port and gets the guess back combinationally, in the same cycle. It also gets the history value that produced the guess and keeps it alongside the branch. When the branch resolves, the back end sends the address, the real outcome and that saved history value to the update port. The update trains the counter that the saved history names, not the one the current history would name. Each update also shifts the real outcome into the global record. The block has no address tags, so addresses that share low bits share counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: Right after reset, the history reads zero and every counter holds the weak not-taken value. That value is 1 with the default 2-bit counters, so every address is predicted not taken until the first update.
- R2: `pred_taken_o` is bit CTR_W-1 of the counter picked by bank `pred_hist_o` and entry `pred_pc_i[3:0]`. It follows a change of `pred_pc_i` within the same cycle, with no clock edge between them.
- R3: An update with outcome 1 (taken) raises the chosen counter by one, and outcome 0 (not taken) lowers it by one. The counter stops at 3 going up and at 0 going down, and never wraps.
- R4: A counter at 3 that sees one not-taken update drops to 2 and still predicts taken. Counter values 2 and 3 predict taken; values 0 and 1 predict not taken.
- R5: Each accepted update shifts `upd_taken_i` into bit 0 of the history, and the old bit 0 moves to bit 1. The new history is visible on `pred_hist_o` in the cycle after the update.
- R6: An update trains only the bank given by `upd_hist_i`. The counters for the same entry in every other bank are left unchanged.
- R7: Only `pc[3:0]` forms the entry index. Addresses that differ only in higher bits share one counter.
- R8: An update changes only the entry at `upd_pc_i[3:0]`. Every other entry keeps its value.
- R9: While `upd_valid_i` is 0, the update inputs change neither the history nor any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Guess: 1 means taken |
| pred_hist_o | output | HIST_W | History value behind the guess; kept with the branch and sent back on update |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Real outcome: 1 means taken |
| upd_hist_i | input | HIST_W | History value saved when the branch was predicted |

## Verification
Counters are driven upward past 3 and downward past 0, in runs long enough that a counter which wrapped instead of saturating would end with the opposite guess. Short runs that stop at value 2 show the one-step slack of R4. One address is trained in one bank, and the global history is then steered through every bank value. This separates a design that trains the bank named by the saved snapshot from one that trains the bank named by the live history or trains all banks. Addresses that differ only above bit 3 check the tagless aliasing of R7. Idle cycles with busy update inputs and a full sweep of every entry check R8 and R9.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned DEF_HIST_W  = 2;
  localparam int unsigned DEF_CTR_W   = 2;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_PC_W    = 32;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int unsigned HIST_W = bp_pkg::DEF_HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  bp_pkg::dir_e      dir_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= dir_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], dir_i};
      end
    end
  endgenerate

  assign hist_o = hist_q;
endmodule

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr #(
  parameter int unsigned CTR_W = bp_pkg::DEF_CTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  output logic [CTR_W-1:0] cnt_o
);
  localparam logic [CTR_W-1:0] CNT_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CNT_INIT = CNT_MAX >> 1;  // weak not-taken

  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_INIT;
    end else if (en_i) begin
      if (up_i && cnt_q != CNT_MAX)       cnt_q <= cnt_q + 1'b1;
      else if (!up_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bp_ctr_array.sv
module bp_ctr_array #(
  parameter int unsigned HIST_W  = bp_pkg::DEF_HIST_W,
  parameter int unsigned CTR_W   = bp_pkg::DEF_CTR_W,
  parameter int unsigned ENTRIES = bp_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned BANKS  = 1 << HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_bank_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_taken_o,
  input  logic              wr_en_i,
  input  logic [HIST_W-1:0] wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_up_i
);
  logic [CTR_W-1:0] cnt [BANKS][ENTRIES];

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic hit;
        assign hit = wr_en_i && (wr_bank_i == HIST_W'(b)) && (wr_idx_i == IDX_W'(e));
        bp_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .en_i   (hit),
          .up_i   (wr_up_i),
          .cnt_o  (cnt[b][e])
        );
      end
    end
  endgenerate

  assign rd_taken_o = cnt[rd_bank_i][rd_idx_i][CTR_W-1];
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int unsigned HIST_W  = bp_pkg::DEF_HIST_W,
  parameter int unsigned CTR_W   = bp_pkg::DEF_CTR_W,
  parameter int unsigned ENTRIES = bp_pkg::DEF_ENTRIES,
  parameter int unsigned PC_W    = bp_pkg::DEF_PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [HIST_W-1:0] ghist;
  logic              unused_pc_hi;
  bp_pkg::dir_e      upd_dir;

  assign upd_dir      = upd_taken_i ? bp_pkg::DIR_TAKEN : bp_pkg::DIR_NOT_TAKEN;
  assign unused_pc_hi = ^{pred_pc_i[PC_W-1:IDX_W], upd_pc_i[PC_W-1:IDX_W]};

  bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .dir_i   (upd_dir),
    .hist_o  (ghist)
  );

  bp_ctr_array #(
    .HIST_W  (HIST_W),
    .CTR_W   (CTR_W),
    .ENTRIES (ENTRIES)
  ) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_bank_i  (ghist),
    .rd_idx_i   (pred_pc_i[IDX_W-1:0]),
    .rd_taken_o (pred_taken_o),
    .wr_en_i    (upd_valid_i),
    .wr_bank_i  (upd_hist_i),
    .wr_idx_i   (upd_pc_i[IDX_W-1:0]),
    .wr_up_i    (upd_taken_i)
  );

  assign pred_hist_o = ghist;
endmodule

// File: rtl/bp_pred_checker.sv
module bp_pred_checker #(
  parameter int unsigned HIST_W = bp_pkg::DEF_HIST_W,
  parameter int unsigned PC_W   = bp_pkg::DEF_PC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i
);
  logic seen_upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_upd_q <= 1'b0;
    else if (upd_valid_i) seen_upd_q <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_upd_q |-> (pred_hist_o == '0 && !pred_taken_o));

  assert_hist_newest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_hist_o[0] == $past(upd_taken_i));

  generate
    if (HIST_W > 1) begin : g_shift
      assert_hist_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> pred_hist_o[HIST_W-1:1] == $past(pred_hist_o[HIST_W-2:0]));
    end
  endgenerate

  assert_hist_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(pred_hist_o));

  assert_pred_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i ##1 $stable(pred_pc_i) |-> $stable(pred_taken_o));
endmodule

bind corr_branch_predictor bp_pred_checker #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_pc_i    (pred_pc_i),
  .pred_taken_o (pred_taken_o),
  .pred_hist_o  (pred_hist_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i)
);

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic [1:0]  pred_hist_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [1:0]  upd_hist_i = '0;

  int total = 0;
  int bad = 0;
  int ref_ctr [4][16];
  logic [1:0] ref_ghr;

  always #5 clk_i = ~clk_i;

  corr_branch_predictor u_corr_branch_predictor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pred_pc_i    (pred_pc_i),
    .pred_taken_o (pred_taken_o),
    .pred_hist_o  (pred_hist_o),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .upd_hist_i   (upd_hist_i)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_pred(input logic [31:0] pc);
    return ref_ctr[ref_ghr][pc[3:0]] >= 2;
  endfunction

  task automatic do_upd(input logic [31:0] pc, input logic t, input logic [1:0] h);
    @(negedge clk_i);
    upd_pc_i = pc; upd_taken_i = t; upd_hist_i = h; upd_valid_i = 1'b1;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    if (t && ref_ctr[h][pc[3:0]] < 3)       ref_ctr[h][pc[3:0]]++;
    else if (!t && ref_ctr[h][pc[3:0]] > 0) ref_ctr[h][pc[3:0]]--;
    ref_ghr = {ref_ghr[0], t};
  endtask

  task automatic pred_at(input logic [31:0] pc, input logic exp, input string req);
    pred_pc_i = pc;
    #1;
    chk(pred_taken_o, exp, req);
    chk(pred_taken_o, model_pred(pc), {req, " model"});
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      pred_pc_i = 32'(i);
      #1;
      chk(pred_taken_o, model_pred(32'(i)), req);
    end
  endtask

  task automatic t_reset();
    chk(pred_hist_o, 2'b00, "R1 history");
    sweep("R1 sweep");
  endtask

  task automatic t_hist();
    do_upd(32'h20, 1'b1, ref_ghr);
    chk(pred_hist_o, 2'b01, "R5 after T");
    do_upd(32'h20, 1'b0, ref_ghr);
    chk(pred_hist_o, 2'b10, "R5 after T,N");
    do_upd(32'h20, 1'b1, ref_ghr);
    chk(pred_hist_o, 2'b01, "R5 after T,N,T");
    do_upd(32'h20, 1'b1, ref_ghr);
    chk(pred_hist_o, 2'b11, "R5 after N,T,T");
  endtask

  task automatic t_hyst();
    do_upd(32'h2, 1'b1, 2'd2);
    do_upd(32'h2, 1'b1, 2'd2);
    do_upd(32'h2, 1'b1, 2'd2);
    do_upd(32'h2, 1'b0, 2'd2);
    chk(pred_hist_o, 2'b10, "R5 steer bank2");
    pred_at(32'h2, 1'b1, "R4 strong minus one stays taken");
    pred_at(32'h3, 1'b0, "R2 same-cycle address change");
    pred_at(32'h2, 1'b1, "R2 same-cycle address back");
  endtask

  task automatic t_sat();
    for (int k = 0; k < 4; k++) do_upd(32'h6, 1'b1, 2'd0);
    do_upd(32'h6, 1'b0, 2'd0);
    do_upd(32'h6, 1'b0, 2'd0);
    pred_at(32'h6, 1'b0, "R3 saturate high then two down");
    for (int k = 0; k < 3; k++) do_upd(32'h7, 1'b0, 2'd0);
    do_upd(32'h7, 1'b1, 2'd0);
    do_upd(32'h7, 1'b1, 2'd0);
    do_upd(32'hC, 1'b0, 2'd3);
    do_upd(32'hC, 1'b0, 2'd3);
    pred_at(32'h7, 1'b1, "R3 saturate low then two up");
    sweep("R3 sweep bank0");
  endtask

  task automatic t_bank();
    do_upd(32'h9, 1'b1, 2'd1);
    do_upd(32'h9, 1'b1, 2'd1);
    pred_at(32'h9, 1'b0, "R6 bank3 untouched");
    do_upd(32'hA, 1'b0, 2'd3);
    pred_at(32'h9, 1'b0, "R6 bank2 untouched");
    do_upd(32'hA, 1'b1, 2'd3);
    pred_at(32'h9, 1'b1, "R6 bank1 trained");
  endtask

  task automatic t_alias();
    do_upd(32'h35, 1'b1, 2'd1);
    do_upd(32'h35, 1'b1, 2'd1);
    do_upd(32'hE, 1'b0, 2'd2);
    do_upd(32'hE, 1'b1, 2'd2);
    chk(pred_hist_o, 2'b01, "R5 steer bank1");
    pred_at(32'h5, 1'b1, "R7 alias low");
    pred_at(32'hF5, 1'b1, "R7 alias mid");
    pred_at(32'h1234_5675, 1'b1, "R7 alias high");
  endtask

  task automatic t_entry();
    pred_at(32'h4, 1'b0, "R8 neighbour entry");
    sweep("R8 sweep bank1");
  endtask

  task automatic t_idle();
    logic [1:0] h0;
    h0 = pred_hist_o;
    @(negedge clk_i);
    for (int k = 0; k < 5; k++) begin
      upd_pc_i = 32'(k); upd_taken_i = k[0]; upd_hist_i = ref_ghr;
      @(negedge clk_i);
    end
    chk(pred_hist_o, h0, "R9 history held");
    sweep("R9 sweep");
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int e = 0; e < 16; e++) ref_ctr[b][e] = 1;
    ref_ghr = 2'b00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_hist();
    t_hyst();
    t_sat();
    t_bank();
    t_alias();
    t_entry();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule